// File: doc/BRIEF.md
# Address Translation Cache with Pinned Entries

This block caches virtual-to-physical page translations for a processor core. It has two storage regions that are searched together. The normal region is set-associative and replaces its entries in turn. The pinned region is fully associative. Its slots are filled only under software control and survive a whole-cache flush. A control word holds two fields: a pin-enable flag and a slot pointer. While the flag is set, every translation handed in by the page-table walker goes into the pinned slot that the pointer names, and the pointer then steps on by one. Software pins a translation by setting the flag, forcing a walk to that address, and clearing the flag again. It can read the control word back at any time to see how far the pointer has moved.

Lookups use a valid/ready stream. A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. Its result appears on the response registers one cycle later. The response stays there unchanged until `rsp_ready` takes it. `req_ready` is low exactly while a response is held and not yet taken, so a stalled consumer stalls the requester without losing a result. The fill, maintenance and control-word ports are plain single-cycle strobes.

Pages come in three sizes: 1 MiB sections, 64 KiB large pages and 4 KiB small pages. Large and small pages each carry four 2-bit access codes, one per quarter-page subpage. A large or small page that goes into a pinned slot is kept as a whole page only if all four codes are equal. Otherwise only the quarter that holds the walk address is stored.

Top module: `xlat_cache`

## Requirements
- R1: After reset the control word reads 0, `rsp_valid` is low, `req_ready` is high and every lookup misses.
- R2: The control word has the pin-enable flag at bit 0 and the slot pointer at bits 28:26. All other bits read 0. A write loads both fields from `reg_wdata`, and a read always returns the live pointer.
- R3: While the flag is set, a fill is stored in the pinned slot named by the pointer, overwriting that slot. The pointer then increments, wrapping from 7 to 0.
- R4: While the flag is clear, a fill goes to the normal region in set `va[23:20]`. Within a set the two ways are written in turn, and the pointer does not change.
- R5: A response is valid the cycle after its request is accepted. On a hit, `rsp_pa` is the stored page base with the page-offset bits of the request address, and on a miss `rsp_hit` is 0.
- R6: When both regions hold a match, the pinned entry is returned, and `rsp_locked` is high exactly for pinned hits.
- R7: A large or small page filled into a pinned slot with unequal subpage codes maps only the quarter holding the fill address (bits 15:14 for large pages, 11:10 for small pages). The other quarters miss.
- R8: A single-address invalidate removes every entry in either region that maps that address, so a later lookup of it misses. It leaves the pointer unchanged.
- R9: A flush empties the normal region and keeps all pinned entries.
- R10: If a control write and a fill happen in the same cycle, the fill is steered by the old flag and pointer, the written value is loaded, and no increment is applied.
- R11: While `rsp_valid` is high and `rsp_ready` is low, every response output holds its value and `req_ready` is low.
- R12: `rsp_ap` is the 2-bit code of the quarter holding the request address: `fill_ap[2k+1:2k]` for quarter k, taken from bits 15:14 for large pages and 11:10 for small pages. A section uses `fill_ap[1:0]` for the whole page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Lookup request can be taken |
| req_va | input | 32 | Lookup virtual address |
| rsp_valid | output | 1 | Lookup result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_hit | output | 1 | Translation found |
| rsp_pa | output | 32 | Translated physical address |
| rsp_ap | output | 2 | Access code for the addressed subpage |
| rsp_locked | output | 1 | Hit came from the pinned region |
| fill_valid | input | 1 | Walk result strobe |
| fill_va | input | 32 | Address that caused the walk |
| fill_ppn | input | 22 | Physical page base, address bits 31:10 |
| fill_kind | input | 2 | 0 section, 1 large page, 2 or 3 small page |
| fill_ap | input | 8 | Four 2-bit subpage access codes |
| reg_wr | input | 1 | Control word write strobe |
| reg_wdata | input | 32 | Control word write value |
| reg_rdata | output | 32 | Control word read value |
| inv_valid | input | 1 | Single-address invalidate strobe |
| inv_va | input | 32 | Address to invalidate |
| flush | input | 1 | Empty the normal region |

## Verification
A lookup result is due on the response outputs one cycle after the edge that accepts the request. Fills, invalidates, flushes and control writes take effect at the edge that samples their strobe, so only lookups accepted on later edges see them. The control word read port shows the new value in the cycle after that edge. The bench changes its inputs on falling edges and samples one nanosecond before the next rising edge. Its scoreboard pops an expected result only in a cycle where a response handshake will complete, so held responses under back-pressure are checked exactly once.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  localparam int VA_W   = 32;
  localparam int PG_LSB = 10;
  localparam int VPN_W  = VA_W - PG_LSB;

  // stored mapping granularity; the two *_Q sizes are pinned quarter pages
  typedef enum logic [2:0] {
    PG_SEC   = 3'd0,
    PG_LARGE = 3'd1,
    PG_LQ    = 3'd2,
    PG_SMALL = 3'd3,
    PG_SQ    = 3'd4
  } pg_size_e;

  typedef struct packed {
    logic             vld;
    logic [VPN_W-1:0] vpn;
    logic [VPN_W-1:0] ppn;
    pg_size_e         size;
    logic [7:0]       ap;
  } xent_t;

  function automatic int unsigned off_bits(pg_size_e s);
    case (s)
      PG_SEC:   return 20;
      PG_LARGE: return 16;
      PG_LQ:    return 14;
      PG_SMALL: return 12;
      default:  return 10;
    endcase
  endfunction

  // ones on the page-number bits that take part in the compare
  function automatic logic [VPN_W-1:0] keep_mask(pg_size_e s);
    logic [VPN_W-1:0] m;
    m = '1;
    return m << (off_bits(s) - PG_LSB);
  endfunction

  function automatic logic ent_match(xent_t e, logic [VPN_W-1:0] vpn);
    return e.vld && (((vpn ^ e.vpn) & keep_mask(e.size)) == '0);
  endfunction

  function automatic logic [VA_W-1:0] ent_pa(xent_t e, logic [VA_W-1:0] va);
    logic [VPN_W-1:0] m;
    m = keep_mask(e.size);
    return {(e.ppn & m) | (va[VA_W-1:PG_LSB] & ~m), va[PG_LSB-1:0]};
  endfunction

  function automatic logic [1:0] ent_ap(xent_t e, logic [VPN_W-1:0] vpn);
    logic [1:0] q;
    case (e.size)
      PG_LARGE, PG_LQ: q = vpn[5:4];
      PG_SMALL, PG_SQ: q = vpn[1:0];
      default:         q = 2'd0;
    endcase
    return e.ap[{q, 1'b0} +: 2];
  endfunction

  // build a stored entry from a walk result; pinned pages with mixed codes shrink to one quarter
  function automatic xent_t make_entry(logic [VPN_W-1:0] vpn, logic [VPN_W-1:0] ppn,
                                       logic [1:0] kind, logic [7:0] ap, logic pin);
    xent_t            e;
    pg_size_e         sz;
    logic [7:0]       a;
    logic [1:0]       q;
    logic             same;
    logic [VPN_W-1:0] m;
    case (kind)
      2'd0:    sz = PG_SEC;
      2'd1:    sz = PG_LARGE;
      default: sz = PG_SMALL;
    endcase
    a    = (sz == PG_SEC) ? {4{ap[1:0]}} : ap;
    same = (a[1:0] == a[3:2]) && (a[1:0] == a[5:4]) && (a[1:0] == a[7:6]);
    m    = keep_mask(sz);
    e.ppn = (ppn & m) | (vpn & ~m);
    if (pin && !same) begin
      q  = (sz == PG_LARGE) ? vpn[5:4] : vpn[1:0];
      sz = (sz == PG_LARGE) ? PG_LQ : PG_SQ;
      a  = {4{a[{q, 1'b0} +: 2]}};
    end
    e.vld  = 1'b1;
    e.size = sz;
    e.vpn  = vpn & keep_mask(sz);
    e.ap   = a;
    return e;
  endfunction

endpackage

// File: rtl/xlat_pin_ctl.sv
module xlat_pin_ctl #(
  parameter int LK_SLOTS = 8,
  parameter int VIC_LSB  = 26,
  localparam int VIC_W   = $clog2(LK_SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [31:0]      wr_data,
  input  logic             fill_en,
  output logic             pin_en,
  output logic [VIC_W-1:0] slot_ptr,
  output logic [31:0]      rd_data
);

  logic [VIC_W-1:0] ptr_step;
  logic             unused_wr;

  assign ptr_step = (slot_ptr == VIC_W'(LK_SLOTS - 1)) ? '0 : slot_ptr + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_en   <= 1'b0;
      slot_ptr <= '0;
    end else if (wr_en) begin
      pin_en   <= wr_data[0];
      slot_ptr <= wr_data[VIC_LSB +: VIC_W];
    end else if (fill_en && pin_en) begin
      slot_ptr <= ptr_step;
    end
  end

  always_comb begin
    rd_data                   = '0;
    rd_data[0]                = pin_en;
    rd_data[VIC_LSB +: VIC_W] = slot_ptr;
  end

  assign unused_wr = ^wr_data;

endmodule

// File: rtl/xlat_pin_bank.sv
module xlat_pin_bank
  import xlat_pkg::*;
#(
  parameter int LK_SLOTS = 8,
  localparam int VIC_W   = $clog2(LK_SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [VIC_W-1:0] wr_idx,
  input  xent_t            wr_ent,
  input  logic             inv_en,
  input  logic [VPN_W-1:0] inv_vpn,
  input  logic [VPN_W-1:0] look_vpn,
  output logic             hit,
  output xent_t            hit_ent
);

  xent_t               slots [LK_SLOTS];
  logic [LK_SLOTS-1:0] hit_vec;

  for (genvar g = 0; g < LK_SLOTS; g++) begin : g_slot
    xent_t ent_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_q <= '0;
      end else begin
        if (inv_en && ent_match(ent_q, inv_vpn)) ent_q.vld <= 1'b0;
        if (wr_en && (wr_idx == VIC_W'(g)))      ent_q     <= wr_ent;
      end
    end
    assign slots[g]   = ent_q;
    assign hit_vec[g] = ent_match(ent_q, look_vpn);
  end

  // lowest slot wins if several overlap
  always_comb begin
    hit_ent = '0;
    for (int i = LK_SLOTS - 1; i >= 0; i--) begin
      if (hit_vec[i]) hit_ent = slots[i];
    end
  end

  assign hit = |hit_vec;

endmodule

// File: rtl/xlat_set_bank.sv
module xlat_set_bank
  import xlat_pkg::*;
#(
  parameter int NSETS   = 16,
  parameter int NWAYS   = 2,
  parameter int IDX_LSB = 20,
  localparam int SET_W  = $clog2(NSETS),
  localparam int WAY_W  = $clog2(NWAYS),
  localparam int IDX_LO = IDX_LSB - PG_LSB
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  xent_t            wr_ent,
  input  logic             inv_en,
  input  logic [VPN_W-1:0] inv_vpn,
  input  logic             flush,
  input  logic [VPN_W-1:0] look_vpn,
  output logic             hit,
  output xent_t            hit_ent
);

  xent_t            ents [NSETS][NWAYS];
  logic [WAY_W-1:0] turn [NSETS];
  logic [SET_W-1:0] wset, iset, lset;

  assign wset = wr_ent.vpn[IDX_LO +: SET_W];
  assign iset = inv_vpn[IDX_LO +: SET_W];
  assign lset = look_vpn[IDX_LO +: SET_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NSETS; s++) begin
        turn[s] <= '0;
        for (int w = 0; w < NWAYS; w++) ents[s][w] <= '0;
      end
    end else begin
      if (flush) begin
        for (int s = 0; s < NSETS; s++)
          for (int w = 0; w < NWAYS; w++) ents[s][w].vld <= 1'b0;
      end
      if (inv_en) begin
        for (int w = 0; w < NWAYS; w++)
          if (ent_match(ents[iset][w], inv_vpn)) ents[iset][w].vld <= 1'b0;
      end
      if (wr_en) begin
        ents[wset][turn[wset]] <= wr_ent;
        turn[wset] <= (turn[wset] == WAY_W'(NWAYS - 1)) ? '0 : turn[wset] + 1'b1;
      end
    end
  end

  always_comb begin
    hit     = 1'b0;
    hit_ent = '0;
    for (int w = NWAYS - 1; w >= 0; w--) begin
      if (ent_match(ents[lset][w], look_vpn)) begin
        hit     = 1'b1;
        hit_ent = ents[lset][w];
      end
    end
  end

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int NSETS    = 16,
  parameter int NWAYS    = 2,
  parameter int LK_SLOTS = 8,
  parameter int IDX_LSB  = 20,
  parameter int VIC_LSB  = 26,
  localparam int VIC_W   = $clog2(LK_SLOTS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [VA_W-1:0] req_va,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic            rsp_hit,
  output logic [VA_W-1:0] rsp_pa,
  output logic [1:0]      rsp_ap,
  output logic            rsp_locked,
  input  logic            fill_valid,
  input  logic [VA_W-1:0] fill_va,
  input  logic [VPN_W-1:0] fill_ppn,
  input  logic [1:0]      fill_kind,
  input  logic [7:0]      fill_ap,
  input  logic            reg_wr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  input  logic            inv_valid,
  input  logic [VA_W-1:0] inv_va,
  input  logic            flush
);

  logic             pin_en;
  logic [VIC_W-1:0] slot_ptr;
  xent_t            new_ent;
  logic             p_hit, n_hit;
  xent_t            p_ent, n_ent, sel_ent;
  logic             take;
  logic             unused_low;

  assign new_ent = make_entry(fill_va[VA_W-1:PG_LSB], fill_ppn, fill_kind, fill_ap, pin_en);

  xlat_pin_ctl #(.LK_SLOTS(LK_SLOTS), .VIC_LSB(VIC_LSB)) u_ctl (
    .clk(clk), .rst_n(rst_n),
    .wr_en(reg_wr), .wr_data(reg_wdata), .fill_en(fill_valid),
    .pin_en(pin_en), .slot_ptr(slot_ptr), .rd_data(reg_rdata)
  );

  xlat_pin_bank #(.LK_SLOTS(LK_SLOTS)) u_pin (
    .clk(clk), .rst_n(rst_n),
    .wr_en(fill_valid && pin_en), .wr_idx(slot_ptr), .wr_ent(new_ent),
    .inv_en(inv_valid), .inv_vpn(inv_va[VA_W-1:PG_LSB]),
    .look_vpn(req_va[VA_W-1:PG_LSB]),
    .hit(p_hit), .hit_ent(p_ent)
  );

  xlat_set_bank #(.NSETS(NSETS), .NWAYS(NWAYS), .IDX_LSB(IDX_LSB)) u_set (
    .clk(clk), .rst_n(rst_n),
    .wr_en(fill_valid && !pin_en), .wr_ent(new_ent),
    .inv_en(inv_valid), .inv_vpn(inv_va[VA_W-1:PG_LSB]), .flush(flush),
    .look_vpn(req_va[VA_W-1:PG_LSB]),
    .hit(n_hit), .hit_ent(n_ent)
  );

  assign sel_ent   = p_hit ? p_ent : n_ent;
  assign req_ready = !rsp_valid || rsp_ready;
  assign take      = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_pa     <= '0;
      rsp_ap     <= '0;
      rsp_locked <= 1'b0;
    end else if (take) begin
      rsp_valid  <= 1'b1;
      rsp_hit    <= p_hit || n_hit;
      rsp_locked <= p_hit;
      rsp_pa     <= (p_hit || n_hit) ? ent_pa(sel_ent, req_va) : '0;
      rsp_ap     <= (p_hit || n_hit) ? ent_ap(sel_ent, req_va[VA_W-1:PG_LSB]) : '0;
    end else if (rsp_ready) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_locked <= 1'b0;
    end
  end

  assign unused_low = ^{fill_va[PG_LSB-1:0], inv_va[PG_LSB-1:0]};

endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
  parameter int LK_SLOTS = 8,
  parameter int VIC_LSB  = 26,
  localparam int VIC_W   = $clog2(LK_SLOTS),
  localparam logic [31:0] KEEP = 32'h1 | (((32'h1 << VIC_W) - 32'h1) << VIC_LSB)
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [31:0] req_va,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic        rsp_hit,
  input logic [31:0] rsp_pa,
  input logic [1:0]  rsp_ap,
  input logic        rsp_locked,
  input logic        fill_valid,
  input logic        reg_wr,
  input logic [31:0] reg_wdata,
  input logic [31:0] reg_rdata,
  input logic        inv_valid,
  input logic [31:0] inv_va
);

  logic        inv_q, fill_q;
  logic [21:0] inv_vpn_q;
  logic        unused_chk;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inv_q     <= 1'b0;
      fill_q    <= 1'b0;
      inv_vpn_q <= '0;
    end else begin
      inv_q     <= inv_valid;
      fill_q    <= fill_valid;
      inv_vpn_q <= inv_va[31:10];
    end
  end

  assign unused_chk = ^{inv_va[9:0], reg_wdata};

  assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & ~KEEP) == 32'h0);

  assert_reg_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> (reg_rdata[VIC_LSB +: VIC_W] == $past(reg_wdata[VIC_LSB +: VIC_W]))
               && (reg_rdata[0] == $past(reg_wdata[0])));

  assert_ptr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && reg_rdata[0] && !reg_wr) |=>
      reg_rdata[VIC_LSB +: VIC_W] == VIC_W'($past(reg_rdata[VIC_LSB +: VIC_W]) + 1'b1));

  // R8: invalidates and flushes leave the control word alone
  assert_ptr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr && !(fill_valid && reg_rdata[0])) |=> $stable(reg_rdata));

  assert_rsp_due_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  assert_pinned_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_locked |-> (rsp_hit && rsp_valid));

  assert_inv_miss_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && inv_q && !fill_q && (req_va[31:10] == inv_vpn_q)) |=> !rsp_hit);

  assert_rsp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_hit) && $stable(rsp_pa)
                                  && $stable(rsp_ap) && $stable(rsp_locked));

  assert_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

endmodule

bind xlat_cache xlat_cache_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit),
  .rsp_pa(rsp_pa), .rsp_ap(rsp_ap), .rsp_locked(rsp_locked),
  .fill_valid(fill_valid), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .inv_valid(inv_valid), .inv_va(inv_va)
);

// File: tb/sim_xlat_cache.sv
module sim_xlat_cache;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, rsp_valid, rsp_ready;
  logic [31:0] req_va, rsp_pa;
  logic        rsp_hit, rsp_locked;
  logic [1:0]  rsp_ap;
  logic        fill_valid;
  logic [31:0] fill_va;
  logic [21:0] fill_ppn;
  logic [1:0]  fill_kind;
  logic [7:0]  fill_ap;
  logic        reg_wr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        inv_valid, flush;
  logic [31:0] inv_va;

  int checks = 0;
  int errors = 0;

  typedef struct {
    bit        hit;
    bit [31:0] pa;
    bit [1:0]  ap;
    bit        lk;
    string     rq;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;

  xlat_cache u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit),
    .rsp_pa(rsp_pa), .rsp_ap(rsp_ap), .rsp_locked(rsp_locked),
    .fill_valid(fill_valid), .fill_va(fill_va), .fill_ppn(fill_ppn),
    .fill_kind(fill_kind), .fill_ap(fill_ap),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .inv_valid(inv_valid), .inv_va(inv_va), .flush(flush)
  );

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic lookup(input logic [31:0] va, input bit hit, input logic [31:0] pa,
                        input logic [1:0] ap, input bit lk, input string rq);
    exp_t e;
    e.hit = hit; e.pa = pa; e.ap = ap; e.lk = lk; e.rq = rq;
    sb.push_back(e);
    @(negedge clk);
    req_valid = 1'b1;
    req_va    = va;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic fill(input logic [31:0] va, input logic [31:0] pa,
                      input logic [1:0] kind, input logic [7:0] ap);
    @(negedge clk);
    fill_valid = 1'b1; fill_va = va; fill_ppn = pa[31:10];
    fill_kind = kind; fill_ap = ap;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic wr_reg(input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [31:0] exp, input string rq);
    @(negedge clk);
    #1;
    check(rq, reg_rdata, exp);
  endtask

  task automatic invalidate(input logic [31:0] va);
    @(negedge clk);
    inv_valid = 1'b1; inv_va = va;
    @(negedge clk);
    inv_valid = 1'b0;
  endtask

  // scoreboard monitor: compare each result in the cycle its handshake completes
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && rsp_valid && rsp_ready) begin
        if (sb.size() == 0) begin
          check("R5 unexpected response", 32'd1, 32'd0);
        end else begin
          e = sb.pop_front();
          check({e.rq, " hit"}, {31'd0, rsp_hit}, {31'd0, e.hit});
          check({e.rq, " locked"}, {31'd0, rsp_locked}, {31'd0, e.lk});
          if (e.hit) begin
            check({e.rq, " pa"}, rsp_pa, e.pa);
            check({e.rq, " ap"}, {30'd0, rsp_ap}, {30'd0, e.ap});
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R5 watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_va = '0; rsp_ready = 1'b1;
    fill_valid = 1'b0; fill_va = '0; fill_ppn = '0; fill_kind = '0; fill_ap = '0;
    reg_wr = 1'b0; reg_wdata = '0; inv_valid = 1'b0; inv_va = '0; flush = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 reg", reg_rdata, 32'h0);
    check("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    check("R1 req_ready", {31'd0, req_ready}, 32'd1);
    lookup(32'h0031_2345, 1'b0, 32'h0, 2'd0, 1'b0, "R1 empty");

    // normal region fills
    fill(32'h0030_0000, 32'h8000_0000, 2'd0, 8'h03);
    lookup(32'h0031_2345, 1'b1, 32'h8001_2345, 2'd3, 1'b0, "R5 section");
    rd_reg(32'h0, "R4 ptr unchanged");
    fill(32'h0050_0000, 32'h1000_0000, 2'd2, 8'hE4);
    fill(32'h1050_0000, 32'h2000_0000, 2'd2, 8'hE4);
    fill(32'h2050_0000, 32'h3000_0000, 2'd2, 8'hE4);
    lookup(32'h0050_0000, 1'b0, 32'h0, 2'd0, 1'b0, "R4 turn evicts way0");
    lookup(32'h1050_0C44, 1'b1, 32'h2000_0C44, 2'd3, 1'b0, "R12 small q3");
    lookup(32'h2050_0400, 1'b1, 32'h3000_0400, 2'd1, 1'b0, "R12 small q1");

    // control word
    wr_reg(32'hFFFF_FFFF);
    rd_reg(32'h1C00_0001, "R2 reserved bits");
    wr_reg(32'h1800_0001);
    rd_reg(32'h1800_0001, "R2 readback");

    // pinned fills
    fill(32'h4000_0000, 32'h9000_0000, 2'd1, 8'hAA);
    rd_reg(32'h1C00_0001, "R3 step");
    lookup(32'h4000_F123, 1'b1, 32'h9000_F123, 2'd2, 1'b1, "R3 pinned large");
    fill(32'h5000_8000, 32'hA000_0000, 2'd1, 8'h1B);
    rd_reg(32'h0000_0001, "R3 wrap");
    lookup(32'h5000_9ABC, 1'b1, 32'hA000_9ABC, 2'd1, 1'b1, "R7 quarter kept");
    lookup(32'h5000_0010, 1'b0, 32'h0, 2'd0, 1'b0, "R7 other quarter");

    // both regions match
    fill(32'h0030_0000, 32'hC000_0000, 2'd0, 8'h01);
    rd_reg(32'h0400_0001, "R3 slot0 then step");
    lookup(32'h0031_2345, 1'b1, 32'hC001_2345, 2'd1, 1'b1, "R6 pinned wins");

    // write and fill in one cycle
    @(negedge clk);
    reg_wr = 1'b1; reg_wdata = 32'h0800_0000;
    fill_valid = 1'b1; fill_va = 32'h6000_1000; fill_ppn = 22'(32'hD000_0000 >> 10);
    fill_kind = 2'd2; fill_ap = 8'hFF;
    @(negedge clk);
    reg_wr = 1'b0; fill_valid = 1'b0;
    rd_reg(32'h0800_0000, "R10 write wins");
    lookup(32'h6000_1234, 1'b1, 32'hD000_0234, 2'd3, 1'b1, "R10 old flag steers");

    // flush
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    lookup(32'h1050_0C44, 1'b0, 32'h0, 2'd0, 1'b0, "R9 normal gone");
    lookup(32'h2050_0400, 1'b0, 32'h0, 2'd0, 1'b0, "R9 normal gone 2");
    lookup(32'h4000_F123, 1'b1, 32'h9000_F123, 2'd2, 1'b1, "R9 pinned kept");
    rd_reg(32'h0800_0000, "R9 ptr kept");

    // single-address invalidate
    invalidate(32'h4000_F000);
    lookup(32'h4000_F123, 1'b0, 32'h0, 2'd0, 1'b0, "R8 pinned removed");
    rd_reg(32'h0800_0000, "R8 ptr kept");
    fill(32'h0070_0000, 32'hE000_0000, 2'd0, 8'h02);
    rd_reg(32'h0800_0000, "R4 ptr kept");
    lookup(32'h007A_BCDE, 1'b1, 32'hE00A_BCDE, 2'd2, 1'b0, "R4 normal section");
    invalidate(32'h0070_0ABC);
    lookup(32'h007A_BCDE, 1'b0, 32'h0, 2'd0, 1'b0, "R8 normal removed");

    // back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    lookup(32'h6000_1234, 1'b1, 32'hD000_0234, 2'd3, 1'b1, "R11 held result");
    repeat (3) @(negedge clk);
    #1;
    check("R11 rsp_valid held", {31'd0, rsp_valid}, 32'd1);
    check("R11 req_ready low", {31'd0, req_ready}, 32'd0);
    check("R11 pa held", rsp_pa, 32'hD000_0234);
    @(negedge clk);
    rsp_ready = 1'b1;

    repeat (4) @(negedge clk);
    #1;
    check("R5 scoreboard drained", sb.size(), 32'd0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule